// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

The block caches the targets of recently resolved branches so the fetch stage can recognise a branch before decode. Each cycle the fetch unit may present a fetch address. One cycle later the block reports whether the word is a known branch, the stored target, and a taken/not-taken prediction. The prediction comes from a 2-bit saturating counter kept in each entry. Storage is organised as 128 sets of 4 ways, 512 entries in total.

The branch execution logic sends an update for each resolved branch.
- If the branch is already present, its counter moves towards taken or not-taken.
- If a taken branch is missing, it is allocated into its set.

The victim is chosen as follows:
- The lowest invalid way is used first.
- Otherwise a per-set 3-bit tree pseudo-LRU picks the way, steered away from locked ways.

A lock command pins or releases the entry that matches an address, so chosen branches survive replacement.

Top module: `branch_tgt_buf`

## Requirements
- R1: After reset every entry is invalid, `hit_o` and `pred_taken_o` are 0, and any lookup misses.
- R2: A lookup presented with `lk_valid` high is answered on the next cycle. `hit_o` is 1 only if a valid entry matches. A cycle with `lk_valid` low yields `hit_o` = 0 on the following cycle.
- R3: Address bits [8:2] select the set and bits [31:9] form the tag. Bits [1:0] are ignored. Four branches with the same set index and different tags are held at once.
- R4: Only a taken update that misses allocates. A not-taken miss leaves the buffer unchanged. A new entry holds the supplied target and starts at counter 10 (weakly taken), so it predicts taken.
- R5: The counter encodes 11 strongly taken, 10 weakly taken, 01 weakly not taken and 00 strongly not taken. An update hit adds one on taken and subtracts one on not-taken, saturating at 11 and 00. `pred_taken_o` is counter bit 1.
- R6: A taken update that hits replaces the stored target with `up_target`.
- R7: A lock-set command (`lock_set` = 1) on a present entry prevents that entry from ever being chosen as a victim.
- R8: If all four ways of a set are locked, an allocation to that set is dropped and the existing entries stay.
- R9: A lock-reset command (`lock_set` = 0) makes the entry replaceable again.
- R10: The victim is the lowest-numbered invalid way if one exists. Otherwise it is the way named by the tree pseudo-LRU, which is refreshed on every lookup hit and every allocation. With all ways unlocked and ways 0..3 allocated in order, the next victim is way 0.
- R11: When an update and a lookup hit the same entry in the same cycle, the lookup returns the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Fetch address to look up |
| up_valid | input | 1 | Resolved-branch update |
| up_addr | input | AW | Address of resolved branch |
| up_taken | input | 1 | Branch outcome, 1 = taken |
| up_target | input | AW | Resolved target address |
| lock_valid | input | 1 | Lock command |
| lock_set | input | 1 | 1 = set lock, 0 = clear lock |
| lock_addr | input | AW | Address of entry to lock or unlock |
| hit_o | output | 1 | Registered lookup hit |
| tgt_o | output | AW | Registered target of hit entry |
| pred_taken_o | output | 1 | Registered taken prediction |

## Verification
On every cycle the assertions check four things:
- A prediction of taken is never given without a hit.
- No hit appears without a preceding lookup.
- Each allocation writes at most one way, and never a locked way.
- A repeated lookup to an unchanged buffer returns identical results.

The directed scenarios are what show the rest: counter saturation at both ends, the pseudo-LRU victim order, dropping of allocations into a fully locked set, release of a lock, and the pre-update value returned on a same-cycle collision.

// File: rtl/branch_tgt_buf.sv
module branch_tgt_buf #(
  parameter int AW    = 32,
  parameter int IDX_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          up_valid,
  input  logic [AW-1:0] up_addr,
  input  logic          up_taken,
  input  logic [AW-1:0] up_target,
  input  logic          lock_valid,
  input  logic          lock_set,
  input  logic [AW-1:0] lock_addr,
  output logic          hit_o,
  output logic [AW-1:0] tgt_o,
  output logic          pred_taken_o
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W - 2;

  logic [TAG_W-1:0] tag_m [SETS][4];
  logic [AW-1:0]    tgt_m [SETS][4];
  logic [1:0]       ctr_m [SETS][4];
  logic [3:0]       vld_m [SETS];
  logic [3:0]       lck_m [SETS];
  logic [2:0]       plru_m[SETS];

  function automatic logic [1:0] enc(input logic [3:0] oh);
    enc = {oh[3] | oh[2], oh[3] | oh[1]};
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    touch = p;
    touch[0] = ~w[1];
    if (w[1]) touch[2] = ~w[0];
    else      touch[1] = ~w[0];
  endfunction

  wire [IDX_W-1:0] lk_idx = lk_addr[IDX_W+1:2];
  wire [TAG_W-1:0] lk_tag = lk_addr[AW-1:IDX_W+2];
  wire [IDX_W-1:0] up_idx = up_addr[IDX_W+1:2];
  wire [TAG_W-1:0] up_tag = up_addr[AW-1:IDX_W+2];
  wire [IDX_W-1:0] lc_idx = lock_addr[IDX_W+1:2];
  wire [TAG_W-1:0] lc_tag = lock_addr[AW-1:IDX_W+2];

  logic [3:0] lk_hitv, up_hitv, lc_hitv;
  always_comb begin
    for (int w = 0; w < 4; w++) begin
      lk_hitv[w] = vld_m[lk_idx][w] && (tag_m[lk_idx][w] == lk_tag);
      up_hitv[w] = vld_m[up_idx][w] && (tag_m[up_idx][w] == up_tag);
      lc_hitv[w] = vld_m[lc_idx][w] && (tag_m[lc_idx][w] == lc_tag);
    end
  end

  wire [1:0] lk_way = enc(lk_hitv);
  wire [1:0] up_way = enc(up_hitv);
  wire [1:0] lc_way = enc(lc_hitv);
  wire       lk_hit = lk_valid && |lk_hitv;
  wire       up_hit = up_valid && |up_hitv;

  wire [3:0] up_lockv = lck_m[up_idx];
  wire [3:0] up_vldv  = vld_m[up_idx];
  wire [2:0] up_plru  = plru_m[up_idx];

  logic [3:0] victim_oh;
  logic       side, sel;
  always_comb begin
    victim_oh = '0;
    side = up_plru[0];
    sel  = 1'b0;
    if (~up_vldv != 4'b0) begin
      for (int w = 3; w >= 0; w--)
        if (!up_vldv[w]) victim_oh = 4'b1 << w;
    end else if (~up_lockv != 4'b0) begin
      if (!side && &up_lockv[1:0]) side = 1'b1;
      else if (side && &up_lockv[3:2]) side = 1'b0;
      sel = side ? up_plru[2] : up_plru[1];
      if (up_lockv[{side, sel}]) sel = ~sel;
      victim_oh[{side, sel}] = 1'b1;
    end
  end

  wire [3:0] alloc_we  = (up_valid && up_taken && !up_hit) ? victim_oh : 4'b0;
  wire [1:0] alloc_way = enc(alloc_we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_m[s]  <= '0;
        lck_m[s]  <= '0;
        plru_m[s] <= '0;
      end
      hit_o        <= 1'b0;
      tgt_o        <= '0;
      pred_taken_o <= 1'b0;
    end else begin
      hit_o        <= lk_hit;
      tgt_o        <= lk_hit ? tgt_m[lk_idx][lk_way] : '0;
      pred_taken_o <= lk_hit && ctr_m[lk_idx][lk_way][1];
      if (lk_hit) plru_m[lk_idx] <= touch(plru_m[lk_idx], lk_way);
      if (lock_valid && |lc_hitv) lck_m[lc_idx][lc_way] <= lock_set;
      if (|alloc_we) begin
        plru_m[up_idx] <= touch(up_plru, alloc_way);
        vld_m[up_idx][alloc_way] <= 1'b1;
        lck_m[up_idx][alloc_way] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (|alloc_we) begin
      tag_m[up_idx][alloc_way] <= up_tag;
      tgt_m[up_idx][alloc_way] <= up_target;
      ctr_m[up_idx][alloc_way] <= 2'b10;
    end else if (up_hit) begin
      if (up_taken) begin
        tgt_m[up_idx][up_way] <= up_target;
        if (ctr_m[up_idx][up_way] != 2'b11)
          ctr_m[up_idx][up_way] <= ctr_m[up_idx][up_way] + 2'b01;
      end else if (ctr_m[up_idx][up_way] != 2'b00) begin
        ctr_m[up_idx][up_way] <= ctr_m[up_idx][up_way] - 2'b01;
      end
    end
  end
endmodule

// File: rtl/branch_tgt_buf_chk.sv
module branch_tgt_buf_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic [AW-1:0] lk_addr,
  input logic          up_valid,
  input logic          hit_o,
  input logic [AW-1:0] tgt_o,
  input logic          pred_taken_o,
  input logic [3:0]    alloc_we,
  input logic [3:0]    up_lockv
);
  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken_o |-> hit_o); // R5

  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !hit_o); // R2

  AST_ALLOC_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_we)); // R10

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    |alloc_we |-> ((alloc_we & up_lockv) == 4'b0)); // R7

  AST_REPEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(lk_valid) && lk_addr == $past(lk_addr) && !$past(up_valid))
    |=> ($stable(hit_o) && $stable(pred_taken_o) && $stable(tgt_o))); // R2
endmodule

bind branch_tgt_buf branch_tgt_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .up_valid(up_valid), .hit_o(hit_o), .tgt_o(tgt_o),
  .pred_taken_o(pred_taken_o), .alloc_we(alloc_we), .up_lockv(up_lockv)
);

// File: tb/sim_branch_tgt_buf.sv
`timescale 1ns/1ps
module sim_branch_tgt_buf;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0, up_valid = 0, up_taken = 0, lock_valid = 0, lock_set = 0;
  logic [31:0] lk_addr = 0, up_addr = 0, up_target = 0, lock_addr = 0;
  logic        hit_o, pred_taken_o;
  logic [31:0] tgt_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  branch_tgt_buf u0 (.*);

  function automatic logic [31:0] ad(input int tag, input int idx);
    ad = {tag[22:0], idx[6:0], 2'b00};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, output logic h, output logic [31:0] t, output logic p);
    @(negedge clk); lk_valid = 1; lk_addr = a;
    @(negedge clk); lk_valid = 0;
    h = hit_o; t = tgt_o; p = pred_taken_o;
  endtask

  task automatic upd(input logic [31:0] a, input logic tk, input logic [31:0] tg);
    @(negedge clk); up_valid = 1; up_addr = a; up_taken = tk; up_target = tg;
    @(negedge clk); up_valid = 0;
  endtask

  task automatic lck(input logic [31:0] a, input logic s);
    @(negedge clk); lock_valid = 1; lock_addr = a; lock_set = s;
    @(negedge clk); lock_valid = 0;
  endtask

  task automatic expect_hit(input string rq, input logic [31:0] a, input logic eh);
    logic h, p; logic [31:0] t;
    look(a, h, t, p);
    chk(rq, h, eh);
  endtask

  task automatic t_reset;
    chk("R1 hit after reset", hit_o, 0);
    chk("R1 pred after reset", pred_taken_o, 0);
    expect_hit("R1 lookup misses", ad(3, 1), 0);
  endtask

  task automatic t_alloc;
    logic h, p; logic [31:0] t;
    upd(ad(7, 2), 0, 32'h1000);
    expect_hit("R4 not-taken miss no alloc", ad(7, 2), 0);
    upd(ad(7, 2), 1, 32'hABC0);
    look(ad(7, 2), h, t, p);
    chk("R4 alloc hit", h, 1);
    chk("R4 alloc target", t, 32'hABC0);
    chk("R4 weakly taken predicts", p, 1);
    @(negedge clk); lk_addr = ad(7, 2); lk_valid = 0;
    @(negedge clk);
    chk("R2 no lookup no hit", hit_o, 0);
  endtask

  task automatic t_index;
    expect_hit("R3 low bits ignored", ad(7, 2) | 32'h3, 1);
    expect_hit("R3 other tag misses", ad(8, 2), 0);
    expect_hit("R3 other index misses", ad(7, 3), 0);
    for (int i = 0; i < 4; i++) upd(ad(40 + i, 30), 1, 32'h100 + i);
    for (int i = 0; i < 4; i++) expect_hit("R3 four ways held", ad(40 + i, 30), 1);
  endtask

  task automatic step(input logic tk, input logic ep, input string rq);
    logic h, p; logic [31:0] t;
    upd(ad(9, 12), tk, 32'h500);
    look(ad(9, 12), h, t, p);
    chk(rq, p, ep);
  endtask

  task automatic t_counter;
    logic h, p; logic [31:0] t;
    upd(ad(9, 12), 1, 32'h500);
    step(0, 0, "R5 10->01");
    step(0, 0, "R5 01->00");
    step(0, 0, "R5 sat 00");
    step(1, 0, "R5 00->01");
    step(1, 1, "R5 01->10");
    step(1, 1, "R5 10->11");
    step(1, 1, "R5 sat 11");
    step(0, 1, "R5 11->10");
    step(0, 0, "R5 10->01 after sat");
    upd(ad(9, 12), 1, 32'h7770);
    look(ad(9, 12), h, t, p);
    chk("R6 target refreshed", t, 32'h7770);
  endtask

  task automatic t_plru;
    for (int i = 0; i < 4; i++) upd(ad(60 + i, 5), 1, 32'h10);
    upd(ad(70, 5), 1, 32'h20);
    expect_hit("R10 way0 evicted", ad(60, 5), 0);
    expect_hit("R10 new entry", ad(70, 5), 1);
    for (int i = 1; i < 4; i++) expect_hit("R10 others kept", ad(60 + i, 5), 1);
  endtask

  task automatic t_lock;
    for (int i = 0; i < 4; i++) upd(ad(80 + i, 9), 1, 32'h30);
    lck(ad(80, 9), 1);
    upd(ad(90, 9), 1, 32'h40);
    expect_hit("R7 locked way kept", ad(80, 9), 1);
    expect_hit("R7 way1 evicted instead", ad(81, 9), 0);
    lck(ad(82, 9), 1); lck(ad(83, 9), 1); lck(ad(90, 9), 1);
    upd(ad(91, 9), 1, 32'h50);
    expect_hit("R8 full-lock alloc dropped", ad(91, 9), 0);
    expect_hit("R8 entry kept", ad(82, 9), 1);
    expect_hit("R8 entry kept", ad(90, 9), 1);
    lck(ad(82, 9), 0);
    upd(ad(92, 9), 1, 32'h60);
    expect_hit("R9 unlocked entry replaced", ad(82, 9), 0);
    expect_hit("R9 new entry present", ad(92, 9), 1);
    expect_hit("R9 locked entry kept", ad(80, 9), 1);
  endtask

  task automatic t_same;
    logic h, p; logic [31:0] t;
    upd(ad(100, 20), 1, 32'h90);
    @(negedge clk);
    lk_valid = 1; lk_addr = ad(100, 20);
    up_valid = 1; up_addr = ad(100, 20); up_taken = 0;
    @(negedge clk); lk_valid = 0; up_valid = 0;
    chk("R11 pre-update pred", pred_taken_o, 1);
    look(ad(100, 20), h, t, p);
    chk("R11 post-update pred", p, 0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_index();
    t_counter();
    t_plru();
    t_lock();
    t_same();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule